// File: doc/BRIEF.md
# Multi-Bank Flash Mode Controller

This block keeps track of the operating mode of every bank in a multi-bank flash device. Each bank can be idle and readable, busy with an embedded program or erase algorithm, or carrying an alternate address space that is overlaid onto one chosen sector. The controller accepts decoded command strobes together with the command address. It checks each command against the device-wide rule that only one bank may leave the readable state at a time, and it records which overlay space is active and which sector it covers.

On the read side the block looks at the host read address and the current mode state and produces a source select. The select tells the datapath whether to return array data, overlay data, busy (undefined) data or a fixed filler word. The array storage, the algorithm timing and the overlay contents belong to other blocks. The algorithm engine reports completion through a single done pulse.

Top module: `flash_bank_mode_ctrl`

## Requirements
- R1: After rst_n is released, and in the cycle after a cmd_reset pulse (even while an algorithm runs), every bank reads mode 0 (Read), ovl_active is 0 and cmd_reject is 0.
- R2: When all banks are in Read, a program or erase command puts the addressed bank in mode 1 (busy) on the next cycle; an alg_done pulse then returns it to mode 0.
- R3: At most one bank is ever outside mode 0; an enter, program or erase command that would break this is rejected: cmd_reject is 1 for one cycle and no mode changes.
- R4: An overlay enter command whose bank field (cmd_addr[15:14]) is not 0 is rejected.
- R5: A command address with any of the reserved bits cmd_addr[10:8] set is rejected for enter, program and erase.
- R6: An accepted enter puts bank 0 in mode 2 (overlay) and latches ovl_type from cmd_ovl_type (0 ID, 1 OTP region, 2 lock word, 3 configuration) and ovl_sector from cmd_addr[13:11].
- R7: With an overlay active, a read of bank 0 at the overlaid sector inside the overlay map gives rd_src 1; other sectors of bank 0 and all other banks give rd_src 0. Address layout: bank [15:14], sector [13:11], offset [10:0].
- R8: A read of the overlaid sector outside the map gives rd_src 3 and rd_undef 1. Map sizes: ID offsets 0..63, OTP 0..255, lock offset 0 only, configuration 0..1.
- R9: A read from a bank in mode 1 gives rd_src 2; reads from other banks are unaffected.
- R10: A program command to the overlaid sector, inside the map, while an OTP (user part), lock or configuration overlay is active moves bank 0 to mode 1; alg_done returns it to mode 2 with the same type and sector.
- R11: A program command while the ID overlay is active, or to the OTP factory part (offsets 0..127), and any erase while an overlay is active, are rejected.
- R12: An exit command returns bank 0 to mode 0 and clears ovl_active; an exit with no overlay in mode 2 is rejected.
- R13: An alg_done pulse while no bank is busy changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_addr | input | 16 | Host read address |
| cmd_addr | input | 16 | Address carried by the current command |
| cmd_ovl_type | input | 2 | Overlay space selected by an enter command |
| cmd_ovl_enter | input | 1 | Overlay enter strobe |
| cmd_ovl_exit | input | 1 | Overlay exit strobe |
| cmd_program | input | 1 | Program start strobe |
| cmd_erase | input | 1 | Erase start strobe |
| cmd_reset | input | 1 | Command reset strobe |
| alg_done | input | 1 | Embedded algorithm finished pulse |
| bank_mode | output | 8 | Two bits per bank, bank b at [2b+1:2b]: 0 Read, 1 busy, 2 overlay |
| rd_src | output | 2 | Read source: 0 array, 1 overlay, 2 busy, 3 filler |
| rd_undef | output | 1 | Read falls in the overlaid sector outside the map |
| ovl_active | output | 1 | An overlay is entered |
| ovl_type | output | 2 | Active overlay space |
| ovl_sector | output | 3 | Sector of bank 0 that carries the overlay |
| cmd_reject | output | 1 | Previous cycle's command was rejected |

## Verification
The bench aims at the exclusion rule: a design that only tracked the addressed bank would let an enter or a second program start while another bank is busy, leaving two banks outside Read. It programs inside an overlay and finishes the algorithm. A controller that forgot where the busy state came from would drop bank 0 back to Read and lose the overlay instead of resuming it. The map edges (ID offsets 63/64, lock offset 0/1, OTP out of range) and the factory half of the OTP region are probed, since an off-by-one in a map width shows up as overlay data where filler belongs or as an accepted program to factory data. Reserved command bits, a stray done pulse and a reset during a busy algorithm round out the set.

// File: rtl/fbm_pkg.sv
package fbm_pkg;

    typedef enum logic [1:0] {
        MODE_READ = 2'd0,
        MODE_BUSY = 2'd1,
        MODE_OVL  = 2'd2
    } bank_mode_e;

    typedef enum logic [1:0] {
        OVL_ID   = 2'd0,
        OVL_OTP  = 2'd1,
        OVL_LOCK = 2'd2,
        OVL_CFG  = 2'd3
    } ovl_kind_e;

    typedef enum logic [1:0] {
        SRC_ARRAY = 2'd0,
        SRC_OVL   = 2'd1,
        SRC_BUSY  = 2'd2,
        SRC_FILL  = 2'd3
    } rd_src_e;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_ENTER = 3'd1,
        CMD_EXIT  = 3'd2,
        CMD_PROG  = 3'd3,
        CMD_ERASE = 3'd4
    } cmd_e;

endpackage

// File: rtl/fbm_addr_split.sv
module fbm_addr_split #(
    parameter int ADDR_W  = 16,
    parameter int BANK_W  = 2,
    parameter int SECT_W  = 3,
    parameter int CMD_LSB = 8
) (
    input  logic [ADDR_W-1:0]                 addr,
    output logic [BANK_W-1:0]                 bank,
    output logic [SECT_W-1:0]                 sect,
    output logic [ADDR_W-BANK_W-SECT_W-1:0]   off,
    output logic                              rsvd_ok
);
    localparam int OFF_W = ADDR_W - BANK_W - SECT_W;

    assign bank    = addr[ADDR_W-1 -: BANK_W];
    assign sect    = addr[OFF_W +: SECT_W];
    assign off     = addr[OFF_W-1:0];
    // bits between the sector field and the command's own low bits
    assign rsvd_ok = (addr[OFF_W-1:CMD_LSB] == '0);
endmodule

// File: rtl/fbm_map_check.sv
module fbm_map_check #(
    parameter int OFF_W    = 11,
    parameter int ID_BITS  = 6,
    parameter int OTP_BITS = 8,
    parameter int CFG_BITS = 1
) (
    input  logic [1:0]       kind,
    input  logic [OFF_W-1:0] off,
    output logic             in_map,
    output logic             factory
);
    import fbm_pkg::*;

    always_comb begin
        in_map = 1'b0;
        unique case (ovl_kind_e'(kind))
            OVL_ID:   in_map = ((off >> ID_BITS) == '0);
            OVL_OTP:  in_map = ((off >> OTP_BITS) == '0);
            OVL_LOCK: in_map = (off == '0);
            OVL_CFG:  in_map = ((off >> CFG_BITS) == '0);
            default:  in_map = 1'b0;
        endcase
    end

    // lower half of the OTP region holds factory data
    assign factory = (ovl_kind_e'(kind) == OVL_OTP) && ((off >> (OTP_BITS - 1)) == '0);
endmodule

// File: rtl/fbm_mode_fsm.sv
module fbm_mode_fsm #(
    parameter int NUM_BANKS = 4,
    parameter int SECT_W    = 3,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  fbm_pkg::cmd_e              cmd,
    input  logic                       cmd_reset,
    input  logic                       alg_done,
    input  logic [BANK_W-1:0]          cmd_bank,
    input  logic [SECT_W-1:0]          cmd_sect,
    input  logic                       cmd_rsvd_ok,
    input  logic                       cmd_in_map,
    input  logic                       cmd_factory,
    input  logic [1:0]                 cmd_kind,
    output logic [NUM_BANKS-1:0][1:0]  modes,
    output logic                       ovl_on,
    output logic [1:0]                 ovl_kind,
    output logic [SECT_W-1:0]          ovl_sect,
    output logic                       reject
);
    import fbm_pkg::*;

    typedef struct packed {
        logic [NUM_BANKS-1:0][1:0] mode;
        logic                      ovl_on;
        logic [1:0]                kind;
        logic [SECT_W-1:0]         sect;
        logic                      resume;
        logic                      reject;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_BANKS-1:0] nonread_q;
    logic                 busy_any_q;
    logic                 ovl_ready_q;
    logic                 prog_in_ovl;

    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            nonread_q[b] = (st_q.mode[b] != MODE_READ);
        end
        busy_any_q = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (st_q.mode[b] == MODE_BUSY) busy_any_q = 1'b1;
        end
    end

    assign ovl_ready_q = st_q.ovl_on && (st_q.mode[0] == MODE_OVL);
    assign prog_in_ovl = ovl_ready_q && (cmd_bank == '0) && (cmd_sect == st_q.sect)
                       && (ovl_kind_e'(st_q.kind) != OVL_ID) && cmd_in_map && !cmd_factory;

    always_comb begin
        st_d        = st_q;
        st_d.reject = 1'b0;

        // algorithm completion: back to overlay if it was started there
        if (alg_done && busy_any_q) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (st_q.mode[b] == MODE_BUSY) begin
                    st_d.mode[b] = st_q.resume ? MODE_OVL : MODE_READ;
                end
            end
            st_d.resume = 1'b0;
        end

        if (cmd_reset) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                st_d.mode[b] = MODE_READ;
            end
            st_d.ovl_on = 1'b0;
            st_d.kind   = OVL_ID;
            st_d.sect   = '0;
            st_d.resume = 1'b0;
        end else begin
            unique case (cmd)
                CMD_ENTER: begin
                    if ((|nonread_q) || (cmd_bank != '0) || !cmd_rsvd_ok) begin
                        st_d.reject = 1'b1;
                    end else begin
                        st_d.mode[0] = MODE_OVL;
                        st_d.ovl_on  = 1'b1;
                        st_d.kind    = cmd_kind;
                        st_d.sect    = cmd_sect;
                    end
                end
                CMD_EXIT: begin
                    if (ovl_ready_q) begin
                        st_d.mode[0] = MODE_READ;
                        st_d.ovl_on  = 1'b0;
                        st_d.kind    = OVL_ID;
                        st_d.sect    = '0;
                    end else begin
                        st_d.reject = 1'b1;
                    end
                end
                CMD_PROG: begin
                    if (!cmd_rsvd_ok) begin
                        st_d.reject = 1'b1;
                    end else if (!(|nonread_q)) begin
                        st_d.mode[cmd_bank] = MODE_BUSY;
                    end else if (prog_in_ovl) begin
                        st_d.mode[0] = MODE_BUSY;
                        st_d.resume  = 1'b1;
                    end else begin
                        st_d.reject = 1'b1;
                    end
                end
                CMD_ERASE: begin
                    if (!cmd_rsvd_ok || (|nonread_q)) begin
                        st_d.reject = 1'b1;
                    end else begin
                        st_d.mode[cmd_bank] = MODE_BUSY;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign modes    = st_q.mode;
    assign ovl_on   = st_q.ovl_on;
    assign ovl_kind = st_q.kind;
    assign ovl_sect = st_q.sect;
    assign reject   = st_q.reject;

    // R3
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(nonread_q) <= 1);

    // R3
    busy_enter_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ENTER && !cmd_reset && (|nonread_q)) |=> (reject && $stable(modes)));

    // R1
    cmd_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (nonread_q == '0 && !ovl_on && !reject));

    // R10
    resume_ovl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alg_done && !cmd_reset && st_q.resume && st_q.mode[0] == MODE_BUSY)
        |=> (st_q.mode[0] == MODE_OVL && ovl_on));

    // R13
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alg_done && !busy_any_q && !cmd_reset && cmd == CMD_NONE) |=> $stable(st_q.mode));

    // R4
    generate
        for (genvar g = 1; g < NUM_BANKS; g++) begin : g_ovl_low
            ovl_low_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.mode[g] != MODE_OVL);
        end
    endgenerate
endmodule

// File: rtl/fbm_read_route.sv
module fbm_read_route #(
    parameter int NUM_BANKS = 4,
    parameter int SECT_W    = 3,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_BANKS-1:0][1:0]  modes,
    input  logic                       ovl_on,
    input  logic [SECT_W-1:0]          ovl_sect,
    input  logic [BANK_W-1:0]          rd_bank,
    input  logic [SECT_W-1:0]          rd_sect,
    input  logic                       rd_in_map,
    output logic [1:0]                 rd_src,
    output logic                       rd_undef
);
    import fbm_pkg::*;

    logic hit_sector;

    assign hit_sector = ovl_on && (rd_bank == '0) && (modes[0] == MODE_OVL)
                      && (rd_sect == ovl_sect);

    always_comb begin
        rd_src   = SRC_ARRAY;
        rd_undef = 1'b0;
        if (modes[rd_bank] == MODE_BUSY) begin
            rd_src = SRC_BUSY;
        end else if (hit_sector) begin
            if (rd_in_map) begin
                rd_src = SRC_OVL;
            end else begin
                rd_src   = SRC_FILL;
                rd_undef = 1'b1;
            end
        end
    end

    // R9
    busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_src == SRC_BUSY) |-> (modes[rd_bank] == MODE_BUSY));

    // R7
    ovl_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_src == SRC_OVL) |-> (ovl_on && rd_bank == '0 && modes[0] == MODE_OVL));
endmodule

// File: rtl/flash_bank_mode_ctrl.sv
module flash_bank_mode_ctrl #(
    parameter int NUM_BANKS = 4,
    parameter int SECT_W    = 3,
    parameter int ADDR_W    = 16,
    parameter int CMD_LSB   = 8,
    parameter int ID_BITS   = 6,
    parameter int OTP_BITS  = 8,
    parameter int CFG_BITS  = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [ADDR_W-1:0]        cmd_addr,
    input  logic [1:0]               cmd_ovl_type,
    input  logic                     cmd_ovl_enter,
    input  logic                     cmd_ovl_exit,
    input  logic                     cmd_program,
    input  logic                     cmd_erase,
    input  logic                     cmd_reset,
    input  logic                     alg_done,
    output logic [2*NUM_BANKS-1:0]   bank_mode,
    output logic [1:0]               rd_src,
    output logic                     rd_undef,
    output logic                     ovl_active,
    output logic [1:0]               ovl_type,
    output logic [SECT_W-1:0]        ovl_sector,
    output logic                     cmd_reject
);
    import fbm_pkg::*;

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int OFF_W  = ADDR_W - BANK_W - SECT_W;

    logic [BANK_W-1:0] c_bank, r_bank;
    logic [SECT_W-1:0] c_sect, r_sect;
    logic [OFF_W-1:0]  c_off, r_off;
    logic              c_rsvd_ok, r_rsvd_unused;
    logic              c_in_map, c_factory, r_in_map, r_factory_unused;
    cmd_e              cmd;
    logic [NUM_BANKS-1:0][1:0] modes;
    logic              ovl_on;
    logic [1:0]        ovl_kind;
    logic [SECT_W-1:0] ovl_sect;

    fbm_addr_split #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .SECT_W(SECT_W), .CMD_LSB(CMD_LSB))
        u_cmd_split (.addr(cmd_addr), .bank(c_bank), .sect(c_sect), .off(c_off), .rsvd_ok(c_rsvd_ok));

    fbm_addr_split #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .SECT_W(SECT_W), .CMD_LSB(CMD_LSB))
        u_rd_split (.addr(rd_addr), .bank(r_bank), .sect(r_sect), .off(r_off), .rsvd_ok(r_rsvd_unused));

    fbm_map_check #(.OFF_W(OFF_W), .ID_BITS(ID_BITS), .OTP_BITS(OTP_BITS), .CFG_BITS(CFG_BITS))
        u_cmd_map (.kind(ovl_kind), .off(c_off), .in_map(c_in_map), .factory(c_factory));

    fbm_map_check #(.OFF_W(OFF_W), .ID_BITS(ID_BITS), .OTP_BITS(OTP_BITS), .CFG_BITS(CFG_BITS))
        u_rd_map (.kind(ovl_kind), .off(r_off), .in_map(r_in_map), .factory(r_factory_unused));

    // one command per cycle: enter, exit, program, erase in that order
    always_comb begin
        if (cmd_ovl_enter)      cmd = CMD_ENTER;
        else if (cmd_ovl_exit)  cmd = CMD_EXIT;
        else if (cmd_program)   cmd = CMD_PROG;
        else if (cmd_erase)     cmd = CMD_ERASE;
        else                    cmd = CMD_NONE;
    end

    fbm_mode_fsm #(.NUM_BANKS(NUM_BANKS), .SECT_W(SECT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .cmd_reset  (cmd_reset),
        .alg_done   (alg_done),
        .cmd_bank   (c_bank),
        .cmd_sect   (c_sect),
        .cmd_rsvd_ok(c_rsvd_ok),
        .cmd_in_map (c_in_map),
        .cmd_factory(c_factory),
        .cmd_kind   (cmd_ovl_type),
        .modes      (modes),
        .ovl_on     (ovl_on),
        .ovl_kind   (ovl_kind),
        .ovl_sect   (ovl_sect),
        .reject     (cmd_reject)
    );

    fbm_read_route #(.NUM_BANKS(NUM_BANKS), .SECT_W(SECT_W)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .modes    (modes),
        .ovl_on   (ovl_on),
        .ovl_sect (ovl_sect),
        .rd_bank  (r_bank),
        .rd_sect  (r_sect),
        .rd_in_map(r_in_map),
        .rd_src   (rd_src),
        .rd_undef (rd_undef)
    );

    assign bank_mode  = modes;
    assign ovl_active = ovl_on;
    assign ovl_type   = ovl_kind;
    assign ovl_sector = ovl_sect;
endmodule

// File: tb/flash_bank_mode_ctrl_test.sv
module flash_bank_mode_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [15:0] cmd_addr = '0;
    logic [1:0]  cmd_ovl_type = '0;
    logic        cmd_ovl_enter = 0, cmd_ovl_exit = 0, cmd_program = 0;
    logic        cmd_erase = 0, cmd_reset = 0, alg_done = 0;
    logic [7:0]  bank_mode;
    logic [1:0]  rd_src;
    logic        rd_undef, ovl_active, cmd_reject;
    logic [1:0]  ovl_type;
    logic [2:0]  ovl_sector;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    flash_bank_mode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .cmd_addr(cmd_addr),
        .cmd_ovl_type(cmd_ovl_type), .cmd_ovl_enter(cmd_ovl_enter),
        .cmd_ovl_exit(cmd_ovl_exit), .cmd_program(cmd_program), .cmd_erase(cmd_erase),
        .cmd_reset(cmd_reset), .alg_done(alg_done), .bank_mode(bank_mode),
        .rd_src(rd_src), .rd_undef(rd_undef), .ovl_active(ovl_active),
        .ovl_type(ovl_type), .ovl_sector(ovl_sector), .cmd_reject(cmd_reject)
    );

    function automatic logic [15:0] mk(input int b, input int s, input int o);
        return {b[1:0], s[2:0], o[10:0]};
    endfunction

    function automatic int md(input int b);
        return int'(bank_mode[2*b +: 2]);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // kind: 0 enter, 1 exit, 2 program, 3 erase, 4 reset, 5 done
    task automatic issue(input int kind, input logic [15:0] a, input logic [1:0] t);
        @(negedge clk);
        cmd_addr = a;
        cmd_ovl_type = t;
        cmd_ovl_enter = (kind == 0);
        cmd_ovl_exit  = (kind == 1);
        cmd_program   = (kind == 2);
        cmd_erase     = (kind == 3);
        cmd_reset     = (kind == 4);
        alg_done      = (kind == 5);
        @(negedge clk);
        cmd_ovl_enter = 0; cmd_ovl_exit = 0; cmd_program = 0;
        cmd_erase = 0; cmd_reset = 0; alg_done = 0;
    endtask

    task automatic rd(input logic [15:0] a);
        rd_addr = a;
        #1;
    endtask

    task automatic t_reset_state();
        chk("R1 modes after reset", int'(bank_mode), 0);
        chk("R1 ovl_active after reset", int'(ovl_active), 0);
        chk("R1 reject after reset", int'(cmd_reject), 0);
        rd(mk(0, 0, 0));
        chk("R1 read source after reset", int'(rd_src), 0);
    endtask

    task automatic t_busy_bank();
        issue(3, mk(2, 1, 0), 0);
        chk("R2 erase makes bank2 busy", md(2), 1);
        chk("R2 erase accepted", int'(cmd_reject), 0);
        rd(mk(2, 3, 5));
        chk("R9 busy bank read src", int'(rd_src), 2);
        rd(mk(1, 3, 5));
        chk("R9 other bank read src", int'(rd_src), 0);
        issue(0, mk(0, 2, 0), 1);
        chk("R3 enter while busy rejected", int'(cmd_reject), 1);
        chk("R3 bank0 unchanged", md(0), 0);
        issue(2, mk(1, 0, 0), 0);
        chk("R3 second program rejected", int'(cmd_reject), 1);
        chk("R3 bank1 stays read", md(1), 0);
        issue(5, 16'h0, 0);
        chk("R2 done returns bank2", md(2), 0);
        issue(2, mk(3, 0, 0), 0);
        chk("R2 program makes bank3 busy", md(3), 1);
        issue(5, 16'h0, 0);
        chk("R2 done returns bank3", md(3), 0);
    endtask

    task automatic t_idle_done();
        issue(5, 16'h0, 0);
        chk("R13 stray done modes", int'(bank_mode), 0);
        chk("R13 stray done reject", int'(cmd_reject), 0);
        chk("R13 stray done overlay", int'(ovl_active), 0);
    endtask

    task automatic t_addr_rules();
        issue(0, mk(1, 2, 0), 1);
        chk("R4 enter in bank1 rejected", int'(cmd_reject), 1);
        chk("R4 no overlay", int'(ovl_active), 0);
        issue(0, mk(0, 2, 11'h100), 1);
        chk("R5 enter with reserved bit rejected", int'(cmd_reject), 1);
        issue(3, mk(1, 2, 11'h400), 0);
        chk("R5 erase with reserved bit rejected", int'(cmd_reject), 1);
        chk("R5 bank1 stays read", md(1), 0);
    endtask

    task automatic t_otp_overlay();
        issue(0, mk(0, 5, 0), 1);
        chk("R6 enter accepted", int'(cmd_reject), 0);
        chk("R6 bank0 overlay mode", md(0), 2);
        chk("R6 type latched", int'(ovl_type), 1);
        chk("R6 sector latched", int'(ovl_sector), 5);
        rd(mk(0, 5, 10));
        chk("R7 overlaid sector in map", int'(rd_src), 1);
        rd(mk(0, 4, 10));
        chk("R7 other sector of bank0", int'(rd_src), 0);
        rd(mk(1, 5, 10));
        chk("R7 other bank", int'(rd_src), 0);
        rd(mk(0, 5, 300));
        chk("R8 OTP out of map src", int'(rd_src), 3);
        chk("R8 OTP out of map undef", int'(rd_undef), 1);
        issue(2, mk(0, 5, 8'h10), 0);
        chk("R11 factory program rejected", int'(cmd_reject), 1);
        chk("R11 bank0 stays overlay", md(0), 2);
        issue(3, mk(0, 5, 0), 0);
        chk("R11 erase in overlay rejected", int'(cmd_reject), 1);
        issue(2, mk(0, 5, 8'h90), 0);
        chk("R10 user OTP program accepted", int'(cmd_reject), 0);
        chk("R10 bank0 busy", md(0), 1);
        rd(mk(0, 5, 8'h90));
        chk("R9 overlay bank busy read", int'(rd_src), 2);
        issue(5, 16'h0, 0);
        chk("R10 resume overlay mode", md(0), 2);
        chk("R10 resume type", int'(ovl_type), 1);
        chk("R10 resume sector", int'(ovl_sector), 5);
        issue(1, 16'h0, 0);
        chk("R12 exit to read", md(0), 0);
        chk("R12 exit clears overlay", int'(ovl_active), 0);
        issue(1, 16'h0, 0);
        chk("R12 exit without overlay rejected", int'(cmd_reject), 1);
    endtask

    task automatic t_id_overlay();
        issue(0, mk(0, 2, 0), 0);
        chk("R6 ID overlay mode", md(0), 2);
        rd(mk(0, 2, 63));
        chk("R7 ID last in map", int'(rd_src), 1);
        rd(mk(0, 2, 64));
        chk("R8 ID first out of map", int'(rd_src), 3);
        issue(2, mk(0, 2, 4), 0);
        chk("R11 program in ID rejected", int'(cmd_reject), 1);
        chk("R11 ID bank stays overlay", md(0), 2);
        issue(4, 16'h0, 0);
        chk("R1 reset clears overlay", int'(ovl_active), 0);
        chk("R1 reset modes", int'(bank_mode), 0);
    endtask

    task automatic t_lock_and_reset();
        issue(0, mk(0, 0, 0), 2);
        rd(mk(0, 0, 0));
        chk("R7 lock word in map", int'(rd_src), 1);
        rd(mk(0, 0, 1));
        chk("R8 lock offset1 filler", int'(rd_src), 3);
        issue(2, mk(0, 0, 0), 2);
        chk("R10 lock program busy", md(0), 1);
        issue(5, 16'h0, 0);
        chk("R10 lock resume", md(0), 2);
        issue(1, 16'h0, 0);
        chk("R12 lock exit", md(0), 0);
        issue(3, mk(3, 1, 0), 0);
        chk("R2 erase bank3", md(3), 1);
        issue(4, 16'h0, 0);
        chk("R1 reset during busy", int'(bank_mode), 0);
        chk("R1 reset reject low", int'(cmd_reject), 0);
    endtask

    initial begin
        #(8 * 100000);
        if (!done_flag) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_busy_bank();
        t_idle_done();
        t_addr_rules();
        t_otp_overlay();
        t_id_overlay();
        t_lock_and_reset();
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule